// File: doc/BRIEF.md
# Byte-Strobe Emulating Read-Modify-Write Bridge

This block connects an upstream APB requester that issues byte-strobed writes to a downstream APB completer that can only store whole words. A read, or a write with every strobe bit set, goes straight through as one downstream transfer. A write with no strobe bit set completes upstream at once and produces no downstream traffic.

A write with some but not all strobe bits set becomes a two-transfer sequence on the downstream side. The bridge first reads the addressed word. It then replaces only the strobed byte lanes with the incoming data and writes the merged word back to the same address. The upstream transfer is held in wait states until the sequence is over. If the read reports an error, the write-back is skipped and the error is returned upstream.

Address, data, strobe and direction are latched at the start of each transfer. The bridge handles one transfer at a time and makes no attempt to keep the sequence atomic against other requesters.

Top module: `rmwb_bridge`

## Requirements
- R1: While reset is active, and afterwards until a transfer starts, up_ready, dn_sel and dn_enable are low.
- R2: An upstream read (up_write=0) becomes exactly one downstream read of the same address, whatever the value of up_strb. The full downstream word is returned on up_rdata, and dn_slverr is returned on up_slverr.
- R3: A write with up_strb all ones becomes exactly one downstream write of up_wdata, with no downstream read. A downstream error on that write is returned on up_slverr.
- R4: A write with up_strb all zeros produces no downstream transfer. up_ready goes high in the first access cycle, with up_slverr low.
- R5: Any other write becomes a downstream read followed by a downstream write, both at the upstream address.
- R6: In the merged word, lane i is data bits [8i+7:8i]. Lanes whose strobe bit is 1 take up_wdata, and lanes whose strobe bit is 0 keep the value read. This holds for sparse patterns such as 0101, 1010 and 1001.
- R7: If the read of a partial write returns dn_slverr=1, no downstream write follows, up_slverr is 1, and the stored word is unchanged.
- R8: up_ready is high for exactly one cycle per upstream transfer, and never while a downstream transfer is in progress.
- R9: Each downstream transfer has one setup cycle (dn_sel=1, dn_enable=0) followed by access cycles. Address, direction and write data hold steady until dn_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_sel | input | 1 | Upstream select |
| up_enable | input | 1 | Upstream access phase |
| up_write | input | 1 | Upstream direction, 1 = write |
| up_addr | input | ADDR_W | Upstream address |
| up_wdata | input | DATA_W | Upstream write data |
| up_strb | input | DATA_W/8 | Upstream byte strobes, bit i covers bits [8i+7:8i] |
| up_ready | output | 1 | Upstream transfer complete |
| up_rdata | output | DATA_W | Upstream read data |
| up_slverr | output | 1 | Upstream error response |
| dn_sel | output | 1 | Downstream select |
| dn_enable | output | 1 | Downstream access phase |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | ADDR_W | Downstream address |
| dn_wdata | output | DATA_W | Downstream full-word write data |
| dn_ready | input | 1 | Downstream transfer complete |
| dn_rdata | input | DATA_W | Downstream read data |
| dn_slverr | input | 1 | Downstream error response |

## Verification
The assertions check the following on every cycle:
- downstream handshake shape and stability while waiting (R9);
- the one-cycle completion pulse (R8);
- which downstream transfer types each upstream request class may produce (R2 to R5);
- for every byte lane of each write-back, a match against either up_wdata or the word just read (R6);
- suppression of the write-back after a read error (R7).

Only the bench scenarios can show the rest, because they need a model of the stored words:
- that an unstrobed byte survives in the completer across many patterns and wait-state settings;
- that reads return identical words whatever strobe is applied;
- that an all-zero strobe leaves storage untouched;
- the exact number of downstream transfers.

// File: rtl/rmwb_pkg.sv
package rmwb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RD_SETUP  = 3'd1,
    ST_RD_ACCESS = 3'd2,
    ST_WR_SETUP  = 3'd3,
    ST_WR_ACCESS = 3'd4,
    ST_DONE      = 3'd5
  } rmwb_state_e;

endpackage

// File: rtl/rmwb_rst_sync.sv
module rmwb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  // Assert asynchronously, release two clock edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rmwb_merge.sv
module rmwb_merge #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] read_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [LANES-1:0]  lane_take,
  output logic [DATA_W-1:0] merged_word
);

  // Lane i covers bits [8i+7:8i]; take the new byte only where selected.
  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    assign merged_word[8*gl +: 8] = lane_take[gl] ? new_word[8*gl +: 8]
                                                  : read_word[8*gl +: 8];
  end

endmodule

// File: rtl/rmwb_capture.sv
module rmwb_capture #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              merge_en,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic [LANES-1:0]  up_strb,
  input  logic              up_write,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [LANES-1:0]  cap_strb,
  output logic              cap_write,
  output logic [DATA_W-1:0] word_q
);

  logic [DATA_W-1:0] merged;
  logic [LANES-1:0]  take_mask;
  logic              word_en;
  logic [DATA_W-1:0] word_d;

  // On reads no lane is taken from the write data, so the merge yields the
  // read word unchanged.
  assign take_mask = cap_write ? cap_strb : '0;

  rmwb_merge #(.DATA_W(DATA_W)) u_merge (
    .read_word   (rd_word),
    .new_word    (word_q),
    .lane_take   (take_mask),
    .merged_word (merged)
  );

  assign word_en = cap_en | merge_en;
  assign word_d  = cap_en ? up_wdata : merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_strb  <= '0;
      cap_write <= 1'b0;
    end else if (cap_en) begin
      cap_addr  <= up_addr;
      cap_strb  <= up_strb;
      cap_write <= up_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/rmwb_fsm.sv
module rmwb_fsm
  import rmwb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_sel,
  input  logic             up_enable,
  input  logic             up_write,
  input  logic [LANES-1:0] up_strb,
  input  logic             cap_write,
  input  logic             dn_ready,
  input  logic             dn_slverr,
  output logic             cap_en,
  output logic             merge_en,
  output logic             dn_sel,
  output logic             dn_enable,
  output logic             dn_write,
  output logic             up_ready,
  output logic             up_slverr
);

  rmwb_state_e state_q, state_d;
  logic        err_q, err_d, err_en;
  logic        strb_full, strb_none, start, dn_done;

  assign strb_full = &up_strb;
  assign strb_none = ~|up_strb;
  assign start     = (state_q == ST_IDLE) && up_sel && !up_enable;
  assign dn_done   = dn_enable && dn_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (!up_write)      state_d = ST_RD_SETUP;
          else if (strb_full) state_d = ST_WR_SETUP;
          else if (strb_none) state_d = ST_DONE;
          else                state_d = ST_RD_SETUP;
        end
      end
      ST_RD_SETUP:  state_d = ST_RD_ACCESS;
      ST_RD_ACCESS: begin
        if (dn_ready) begin
          if (cap_write && !dn_slverr) state_d = ST_WR_SETUP;
          else                         state_d = ST_DONE;
        end
      end
      ST_WR_SETUP:  state_d = ST_WR_ACCESS;
      ST_WR_ACCESS: if (dn_ready) state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Error flag: cleared when a transfer starts, loaded at each downstream
  // completion.
  assign err_en = start | dn_done;
  assign err_d  = start ? 1'b0 : dn_slverr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign cap_en    = start;
  assign merge_en  = (state_q == ST_RD_ACCESS) && dn_ready;
  assign dn_sel    = (state_q == ST_RD_SETUP) || (state_q == ST_RD_ACCESS) ||
                     (state_q == ST_WR_SETUP) || (state_q == ST_WR_ACCESS);
  assign dn_enable = (state_q == ST_RD_ACCESS) || (state_q == ST_WR_ACCESS);
  assign dn_write  = (state_q == ST_WR_SETUP) || (state_q == ST_WR_ACCESS);
  assign up_ready  = (state_q == ST_DONE);
  assign up_slverr = up_ready && err_q;

endmodule

// File: rtl/rmwb_bridge.sv
module rmwb_bridge #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_sel,
  input  logic              up_enable,
  input  logic              up_write,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic [LANES-1:0]  up_strb,
  output logic              up_ready,
  output logic [DATA_W-1:0] up_rdata,
  output logic              up_slverr,
  output logic              dn_sel,
  output logic              dn_enable,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_ready,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_slverr
);

  logic             rst_sync_n;
  logic             cap_en, merge_en, cap_write;
  logic [LANES-1:0] cap_strb;
  logic [DATA_W-1:0] word_q;

  rmwb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rmwb_fsm #(.LANES(LANES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .up_sel    (up_sel),
    .up_enable (up_enable),
    .up_write  (up_write),
    .up_strb   (up_strb),
    .cap_write (cap_write),
    .dn_ready  (dn_ready),
    .dn_slverr (dn_slverr),
    .cap_en    (cap_en),
    .merge_en  (merge_en),
    .dn_sel    (dn_sel),
    .dn_enable (dn_enable),
    .dn_write  (dn_write),
    .up_ready  (up_ready),
    .up_slverr (up_slverr)
  );

  rmwb_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cap_en    (cap_en),
    .merge_en  (merge_en),
    .up_addr   (up_addr),
    .up_wdata  (up_wdata),
    .up_strb   (up_strb),
    .up_write  (up_write),
    .rd_word   (dn_rdata),
    .cap_addr  (dn_addr),
    .cap_strb  (cap_strb),
    .cap_write (cap_write),
    .word_q    (word_q)
  );

  // A single word register carries the full-write data, the merged word
  // and the returned read word.
  assign dn_wdata = word_q;
  assign up_rdata = word_q;

endmodule

// File: rtl/rmwb_checker.sv
module rmwb_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_sel,
  input logic              up_enable,
  input logic              up_write,
  input logic [ADDR_W-1:0] up_addr,
  input logic [DATA_W-1:0] up_wdata,
  input logic [LANES-1:0]  up_strb,
  input logic              up_ready,
  input logic [DATA_W-1:0] up_rdata,
  input logic              up_slverr,
  input logic              dn_sel,
  input logic              dn_enable,
  input logic              dn_write,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [DATA_W-1:0] dn_wdata,
  input logic              dn_ready,
  input logic [DATA_W-1:0] dn_rdata,
  input logic              dn_slverr
);

  logic [DATA_W-1:0] rd_hold;
  logic              rd_seen, rd_err;
  logic              rd_done, partial;

  assign rd_done = dn_sel && dn_enable && dn_ready && !dn_write;
  assign partial = up_write && !(&up_strb) && (|up_strb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hold <= '0;
      rd_seen <= 1'b0;
      rd_err  <= 1'b0;
    end else begin
      if (rd_done) rd_hold <= dn_rdata;
      if (up_ready) begin
        rd_seen <= 1'b0;
        rd_err  <= 1'b0;
      end else if (rd_done) begin
        rd_seen <= 1'b1;
        rd_err  <= dn_slverr && up_write;
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !up_ready && !dn_sel && !dn_enable);

  p_read_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_sel && !up_write) |-> !(dn_sel && dn_write));

  p_full_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_sel && up_write && (&up_strb)) |-> !(dn_sel && !dn_write));

  p_zero_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_sel && up_write && !(|up_strb)) |-> !dn_sel);

  p_same_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_sel && dn_sel) |-> (dn_addr == up_addr));

  p_read_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_sel && partial && dn_sel && dn_write) |-> rd_seen);

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane_chk
    p_lane_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_sel && dn_sel && dn_write && up_strb[gl])
        |-> (dn_wdata[8*gl +: 8] == up_wdata[8*gl +: 8]));
    p_lane_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_sel && dn_sel && dn_write && !up_strb[gl])
        |-> (dn_wdata[8*gl +: 8] == rd_hold[8*gl +: 8]));
  end

  p_err_nowb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> !(dn_sel && dn_write));

  p_err_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (up_ready && up_slverr));

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready);

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |-> !dn_sel);

  p_setup_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_sel && !dn_enable) |=> (dn_sel && dn_enable));

  p_enable_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_enable |-> dn_sel);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_sel && dn_enable && !dn_ready)
      |=> (dn_sel && dn_enable && $stable(dn_addr) && $stable(dn_write)
           && $stable(dn_wdata)));

endmodule

bind rmwb_bridge rmwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_sel    (up_sel),
  .up_enable (up_enable),
  .up_write  (up_write),
  .up_addr   (up_addr),
  .up_wdata  (up_wdata),
  .up_strb   (up_strb),
  .up_ready  (up_ready),
  .up_rdata  (up_rdata),
  .up_slverr (up_slverr),
  .dn_sel    (dn_sel),
  .dn_enable (dn_enable),
  .dn_write  (dn_write),
  .dn_addr   (dn_addr),
  .dn_wdata  (dn_wdata),
  .dn_ready  (dn_ready),
  .dn_rdata  (dn_rdata),
  .dn_slverr (dn_slverr)
);

// File: tb/sim_rmwb_bridge.sv
`timescale 1ns/1ps
module sim_rmwb_bridge;

  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NL = DW / 8;
  localparam logic [AW-1:0] ERR_ADDR = 12'h00C;

  typedef struct packed {
    logic [1:0]  widx;
    logic [3:0]  strb;
    logic [31:0] wdata;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{2'd0, 4'b0001, 32'h1111_1101},
    '{2'd0, 4'b0010, 32'h2222_0222},
    '{2'd1, 4'b0100, 32'h3303_3333},
    '{2'd1, 4'b1000, 32'h0444_4444},
    '{2'd2, 4'b0011, 32'h5555_A5B5},
    '{2'd2, 4'b1100, 32'hC6D6_6666},
    '{2'd0, 4'b0101, 32'h7777_7777},
    '{2'd1, 4'b1010, 32'h8888_8888},
    '{2'd2, 4'b1001, 32'h9999_9999},
    '{2'd0, 4'b0110, 32'hAAAA_AAAA},
    '{2'd1, 4'b0111, 32'hBBBB_BBBB},
    '{2'd2, 4'b1110, 32'hCCCC_CCCC},
    '{2'd0, 4'b1111, 32'hDEAD_BEEF},
    '{2'd1, 4'b0000, 32'hFFFF_FFFF},
    '{2'd2, 4'b1011, 32'h1357_9BDF},
    '{2'd1, 4'b1101, 32'h2468_ACE0}
  };

  logic          clk;
  logic          rst_n;
  logic          up_sel, up_enable, up_write;
  logic [AW-1:0] up_addr;
  logic [DW-1:0] up_wdata;
  logic [NL-1:0] up_strb;
  logic          up_ready, up_slverr;
  logic [DW-1:0] up_rdata;
  logic          dn_sel, dn_enable, dn_write;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic          dn_ready, dn_slverr;
  logic [DW-1:0] dn_rdata;

  rmwb_bridge #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .up_sel(up_sel), .up_enable(up_enable), .up_write(up_write),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_strb(up_strb),
    .up_ready(up_ready), .up_rdata(up_rdata), .up_slverr(up_slverr),
    .dn_sel(dn_sel), .dn_enable(dn_enable), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ready(dn_ready), .dn_rdata(dn_rdata), .dn_slverr(dn_slverr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Downstream word-only completer model with programmable wait states.
  logic [DW-1:0] smem [4];
  logic          op_wr [8];
  logic [AW-1:0] op_ad [8];
  int            op_cnt, wcnt, wait_cfg, rdy_cnt;

  assign dn_ready  = dn_sel && dn_enable && (wcnt == wait_cfg);
  assign dn_rdata  = smem[dn_addr[3:2]];
  assign dn_slverr = dn_ready && (dn_addr == ERR_ADDR);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) smem[k] <= 32'hA0B0_C0D0 + k;
      op_cnt <= 0;
      wcnt   <= 0;
    end else if (dn_sel && dn_enable) begin
      if (dn_ready) begin
        wcnt <= 0;
        if (dn_write && !dn_slverr) smem[dn_addr[3:2]] <= dn_wdata;
        op_wr[op_cnt % 8] <= dn_write;
        op_ad[op_cnt % 8] <= dn_addr;
        op_cnt <= op_cnt + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_cnt <= 0;
    else if (up_ready) rdy_cnt <= rdy_cnt + 1;
  end

  int checks, fails;
  logic [DW-1:0] ref_mem [4];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One upstream transfer; returns data, error, latency, downstream op count.
  task automatic xfer(input logic wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [NL-1:0] s,
                      output logic [DW-1:0] rd, output logic er,
                      output int lat, output int nops, output int op0);
    int c0, r0, guard;
    c0 = op_cnt;
    r0 = rdy_cnt;
    @(negedge clk);
    up_sel = 1'b1; up_enable = 1'b0; up_write = wr;
    up_addr = a; up_wdata = d; up_strb = s;
    @(negedge clk);
    up_enable = 1'b1;
    lat = 0;
    guard = 0;
    while (!up_ready && guard < 200) begin
      @(negedge clk);
      lat++;
      guard++;
    end
    if (!up_ready) begin
      checks++; fails++;
      $display("FAIL R8 transfer hang actual=%h expected=%h", 0, 1);
    end
    rd = up_rdata;
    er = up_slverr;
    @(negedge clk);
    up_sel = 1'b0; up_enable = 1'b0;
    @(negedge clk);
    nops = op_cnt - c0;
    op0 = c0;
    chk("R8", "ready pulses per transfer", rdy_cnt - r0, 1);
  endtask

  function automatic logic [DW-1:0] overlay(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [NL-1:0] s);
    logic [DW-1:0] r;
    r = old;
    for (int i = 0; i < NL; i++) if (s[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] rd, rd2;
    logic          er;
    int            lat, nops, op0;
    checks = 0; fails = 0;
    up_sel = 0; up_enable = 0; up_write = 0;
    up_addr = '0; up_wdata = '0; up_strb = '0;
    wait_cfg = 0;
    rst_n = 1'b0;
    for (int k = 0; k < 4; k++) ref_mem[k] = 32'hA0B0_C0D0 + k;
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", up_ready, 0);
    chk("R1", "dn_sel in reset", dn_sel, 0);
    chk("R1", "dn_enable in reset", dn_enable, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle after reset", {up_ready, dn_sel, dn_enable}, 0);

    // Table of write patterns, each compared against a byte-overlay model.
    for (int v = 0; v < 16; v++) begin
      logic [AW-1:0] a;
      int exp_ops;
      wait_cfg = v % 3;
      a = {8'h00, VECS[v].widx, 2'b00};
      xfer(1'b1, a, VECS[v].wdata, VECS[v].strb, rd, er, lat, nops, op0);
      ref_mem[VECS[v].widx] = overlay(ref_mem[VECS[v].widx], VECS[v].wdata, VECS[v].strb);
      exp_ops = (VECS[v].strb == 4'hF) ? 1 : (VECS[v].strb == 4'h0) ? 0 : 2;
      chk("R6", "merged word stored", smem[VECS[v].widx], ref_mem[VECS[v].widx]);
      chk("R5", "downstream op count", nops, exp_ops);
      chk("R5", "no error", er, 0);
      if (exp_ops == 2) begin
        chk("R5", "first op is read", op_wr[op0 % 8], 0);
        chk("R5", "second op is write", op_wr[(op0 + 1) % 8], 1);
        chk("R5", "read address", op_ad[op0 % 8], a);
        chk("R5", "write address", op_ad[(op0 + 1) % 8], a);
      end else if (exp_ops == 1) begin
        chk("R3", "full write is a write", op_wr[op0 % 8], 1);
      end else begin
        chk("R4", "zero strobe latency", lat, 0);
      end
    end

    // R2: reads ignore strobes and return the full word.
    wait_cfg = 1;
    xfer(1'b0, 12'h004, 32'h0, 4'b0000, rd, er, lat, nops, op0);
    chk("R2", "read data strb 0", rd, ref_mem[1]);
    chk("R2", "read op count", nops, 1);
    chk("R2", "read op is read", op_wr[op0 % 8], 0);
    xfer(1'b0, 12'h004, 32'hFFFF_FFFF, 4'b1111, rd2, er, lat, nops, op0);
    chk("R2", "read data strb F", rd2, rd);
    chk("R2", "read op count strb F", nops, 1);
    chk("R2", "read word unchanged", smem[1], ref_mem[1]);
    xfer(1'b0, ERR_ADDR, 32'h0, 4'b0101, rd, er, lat, nops, op0);
    chk("R2", "read error forwarded", er, 1);
    chk("R2", "read data on error", rd, ref_mem[3]);

    // R4: zero strobe under waits leaves every word untouched.
    wait_cfg = 2;
    xfer(1'b1, 12'h008, 32'h0BAD_0BAD, 4'b0000, rd, er, lat, nops, op0);
    chk("R4", "zero strobe no ops", nops, 0);
    chk("R4", "zero strobe latency", lat, 0);
    chk("R4", "zero strobe no error", er, 0);
    chk("R4", "zero strobe word kept", smem[2], ref_mem[2]);

    // R7: read error on a partial write suppresses the write-back.
    xfer(1'b1, ERR_ADDR, 32'h1234_5678, 4'b0011, rd, er, lat, nops, op0);
    chk("R7", "error reported", er, 1);
    chk("R7", "only the read issued", nops, 1);
    chk("R7", "op was read", op_wr[op0 % 8], 0);
    chk("R7", "word unchanged", smem[3], ref_mem[3]);

    // R3: full write error passes through unchanged.
    xfer(1'b1, ERR_ADDR, 32'h8765_4321, 4'b1111, rd, er, lat, nops, op0);
    chk("R3", "full write error", er, 1);
    chk("R3", "single write op", nops, 1);
    chk("R3", "op was write", op_wr[op0 % 8], 1);

    // R6: read back every word through the bridge.
    wait_cfg = 0;
    for (int k = 0; k < 3; k++) begin
      xfer(1'b0, {8'h00, 2'(k), 2'b00}, 32'h0, 4'b1010, rd, er, lat, nops, op0);
      chk("R6", "readback", rd, ref_mem[k]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule